// File: doc/BRIEF.md
# Clock Generator Configuration Serial Slave

This block is the two-wire serial slave that holds the configuration of a system clock generator. A host reaches it at the 7-bit address 0x69. Every transfer starts at the beginning of the register image. There is no register pointer and no random access.

A write carries a command byte and a count byte. Both are acknowledged and then discarded. The data bytes that follow land in configuration bytes 0, 1, 2 and so on. The host may send STOP after any complete byte.

A read first returns the number of configuration bytes and then the bytes themselves in ascending order.

Some bits are not stored. They show live external pin levels: the two clock-stop pins and the current-multiplier select pin. Byte 0's frequency-select field is loaded from pins at reset and can be overwritten later. The whole image is presented as a parallel bus so that the clock generator logic can decode it.

SCL and SDA are sampled by a system clock that runs much faster than standard mode (100 kbit/s or slower). SDA is driven through an open-drain enable.

Top module: `smb_cfg_slave`

## Requirements
- R1: The slave acknowledges the address bytes 0xD2 (write) and 0xD3 (read). For any other address byte it leaves SDA released for the acknowledge bit and for the rest of that transfer.
- R2: In a write, the first two bytes after the address are a command byte and a count byte. Each is acknowledged, and neither value changes any configuration bit.
- R3: The data bytes of a write are stored into configuration bytes 0, 1, 2 … in arrival order, and each one is acknowledged. A stored value appears on `cfg_o` only while SCL is low.
- R4: A STOP after any complete data byte ends the write. Bytes that were not reached keep their values. The next write again starts at byte 0.
- R5: A read returns 0x07 first, then configuration bytes 0 through 6 in ascending order, each sent MSB first. A host acknowledge asks for the next byte, and a host not-acknowledge ends the read.
- R6: After reset, byte 1 has its stored bits at 0x07, byte 2 = 0x7F, byte 3 = 0xC7, byte 4 = 0x3F and byte 5 = 0x00. Byte 0 bits 7, 6 and 5 are 0.
- R7: Pins are mirrored into three read-only bits, and writes to these bits have no effect:
  - byte 0 bit 4 shows `cpu_stop_pin`;
  - byte 0 bit 3 shows `pci_stop_pin`;
  - byte 1 bit 7 shows `mult_pin`.
- R8: Data bytes past byte 5 are acknowledged and ignored. Byte 6 always reads 0xFF.
- R9: Every START, including a repeated START, restarts the read sequence at the count byte.
- R10: At reset, byte 0 bits 2..0 take the value of `fs_pin`. A write can change them afterwards.
- R11: The slave changes its SDA drive only while SCL is low.

Configuration byte k sits at `cfg_o[8k+7:8k]`. The stored controls are:
- Byte 0 bit 7: spread enable.
- Byte 0 bit 6: power-down park level.
- Byte 0 bit 5: 48 MHz select for the shared output.
- Byte 1 bit 6: stop park level.
- Byte 1 bits 5..3: free-run flags.
- Byte 1 bits 2..0 and bytes 2 to 4: output enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | Pulls SDA low when 1 |
| fs_pin | input | 3 | Frequency-select pins, captured at reset |
| cpu_stop_pin | input | 1 | CPU clock stop pin level |
| pci_stop_pin | input | 1 | PCI clock stop pin level |
| mult_pin | input | 1 | Current-multiplier select pin level |
| cfg_o | output | 56 | Configuration image, byte k at bits 8k+7:8k |

## Verification
A wrong byte pointer shows up as a whole byte landing in the wrong `cfg_o` lane. That error is visible at the STOP of the write that caused it, and it is visible again in the data phase of the next block read. A wrong bit counter shows up within one byte time, either as a missing acknowledge or as a byte that reads back rotated. The bench checks `cfg_o` against its own model after every write. It sweeps patterns through all bytes, including the read-only and out-of-range ones, so that a dropped write mask or a stale pin mirror appears in the first check after the fault.

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h69
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [2:0]  fs_pin,
  input  logic        cpu_stop_pin,
  input  logic        pci_stop_pin,
  input  logic        mult_pin,
  output logic [55:0] cfg_o
);
  localparam int NREG = 7;
  localparam int NWR  = 6;
  localparam logic [8*NREG-1:0] DEF   = 56'hFF_00_3F_C7_7F_07_00;
  localparam logic [8*NREG-1:0] WMASK = 56'h00_FF_FF_FF_FF_7F_E7;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_RACK, ST_TX, ST_TACK} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic       scl_q, sda_q;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;
  st_t        st;
  logic [3:0] bitcnt, ptr;
  logic [7:0] sr, tx_byte;
  logic       rw, addr_ph, nack, boot;
  logic [8*NWR-1:0] regs;
  logic       st_idle;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= 2'b11; sda_sy <= 2'b11; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_q  <= scl_sy[1];
      sda_q  <= sda_sy[1];
    end

  assign scl_s     = scl_sy[1];
  assign sda_s     = sda_sy[1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign st_idle   = (st == ST_IDLE);

  always_comb begin
    cfg_o = ({8'h00, regs} & WMASK) | (DEF & ~WMASK);
    cfg_o[4]  = cpu_stop_pin;
    cfg_o[3]  = pci_stop_pin;
    cfg_o[15] = mult_pin;
  end

  always_comb begin
    if (ptr == 4'd0)             tx_byte = 8'(NREG);
    else if (ptr <= 4'(NREG))    tx_byte = cfg_o[{ptr - 4'd1, 3'b000} +: 8];
    else                         tx_byte = 8'hFF;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= ST_IDLE; bitcnt <= '0; ptr <= '0; sr <= '0; rw <= 1'b0;
      addr_ph <= 1'b0; nack <= 1'b0; sda_oe <= 1'b0; boot <= 1'b1;
      regs <= DEF[8*NWR-1:0];
    end else begin
      boot <= 1'b0;
      if (boot) regs[2:0] <= fs_pin;
      if (start_det) begin
        st <= ST_RX; bitcnt <= '0; addr_ph <= 1'b1; ptr <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= ST_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          ST_RX:
            if (scl_rise && bitcnt != 4'd8) begin
              sr <= {sr[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              addr_ph <= 1'b0;
              if (addr_ph) begin
                if (sr[7:1] == DEV_ADDR) begin
                  rw <= sr[0]; sda_oe <= 1'b1; st <= ST_RACK;
                end else st <= ST_IDLE;
              end else begin
                sda_oe <= 1'b1; st <= ST_RACK;
                if (ptr >= 4'd2 && ptr < 4'(2 + NWR))
                  regs[{ptr - 4'd2, 3'b000} +: 8] <= sr;
                if (ptr != 4'hF) ptr <= ptr + 4'd1;
              end
            end
          ST_RACK:
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sr <= tx_byte; sda_oe <= ~tx_byte[7]; st <= ST_TX;
                if (ptr != 4'hF) ptr <= ptr + 4'd1;
              end else begin
                sda_oe <= 1'b0; st <= ST_RX;
              end
            end
          ST_TX:
            if (scl_fall) begin
              if (bitcnt == 4'd7) begin
                sda_oe <= 1'b0; st <= ST_TACK;
              end else begin
                sr <= {sr[6:0], 1'b0}; sda_oe <= ~sr[6]; bitcnt <= bitcnt + 4'd1;
              end
            end
          ST_TACK:
            if (scl_rise) nack <= sda_s;
            else if (scl_fall) begin
              if (nack) st <= ST_IDLE;
              else begin
                sr <= tx_byte; sda_oe <= ~tx_byte[7]; bitcnt <= '0; st <= ST_TX;
                if (ptr != 4'hF) ptr <= ptr + 4'd1;
              end
            end
          default: st <= ST_IDLE;
        endcase
      end
    end
endmodule

// File: rtl/smb_cfg_slave_chk.sv
module smb_cfg_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_i,
  input logic        sda_oe,
  input logic [31:0] cfg_mid,
  input logic        st_idle,
  input logic        start_seen,
  input logic [3:0]  ptr
);
  a_r11_drive_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);
  a_r11_release_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_i);
  a_r3_store_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_mid) |-> !scl_i);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st_idle && $past(st_idle)) |-> !sda_oe);
  a_r9_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_seen) |-> ptr == 4'd0);
endmodule

bind smb_cfg_slave smb_cfg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_mid(cfg_o[47:16]), .st_idle(st_idle), .start_seen(start_det), .ptr(ptr)
);

// File: tb/smb_cfg_slave_tb.sv
`timescale 1ns/1ps
module smb_cfg_slave_tb;
  localparam int HALF = 160;
  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_d = 1'b1, sda_d = 1'b1;
  logic sda_oe, sda_w;
  logic [2:0] fs_pin = 3'b101;
  logic cpu_stop_pin = 1'b1, pci_stop_pin = 1'b0, mult_pin = 1'b1;
  logic [55:0] cfg_o;
  int total = 0, fails = 0;
  logic [7:0] mem [7];
  logic [7:0] wd [10];
  logic r11_bad = 1'b0;
  logic ack;
  logic [7:0] rb;

  localparam logic [55:0] DEFV  = 56'hFF_00_3F_C7_7F_07_00;
  localparam logic [55:0] WMSKV = 56'h00_FF_FF_FF_FF_7F_E7;

  always #4 clk = ~clk;
  assign sda_w = sda_d & ~sda_oe;

  smb_cfg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_d), .sda_i(sda_w), .sda_oe(sda_oe),
    .fs_pin(fs_pin), .cpu_stop_pin(cpu_stop_pin), .pci_stop_pin(pci_stop_pin),
    .mult_pin(mult_pin), .cfg_o(cfg_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expb(input int k);
    logic [7:0] b;
    b = (mem[k] & WMSKV[8*k +: 8]) | (DEFV[8*k +: 8] & ~WMSKV[8*k +: 8]);
    if (k == 0) begin b[4] = cpu_stop_pin; b[3] = pci_stop_pin; end
    if (k == 1) b[7] = mult_pin;
    return b;
  endfunction

  function automatic logic [55:0] expv();
    logic [55:0] v;
    for (int k = 0; k < 7; k++) v[8*k +: 8] = expb(k);
    return v;
  endfunction

  task automatic start_c();
    sda_d = 1'b1; #HALF; scl_d = 1'b1; #HALF; sda_d = 1'b0; #HALF; scl_d = 1'b0;
  endtask

  task automatic stop_c();
    sda_d = 1'b0; #HALF; scl_d = 1'b1; #HALF; sda_d = 1'b1; #HALF;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic a);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; #HALF; scl_d = 1'b1; #HALF; scl_d = 1'b0;
    end
    sda_d = 1'b1; #HALF; scl_d = 1'b1; #(HALF/2); a = ~sda_w; #(HALF/2); scl_d = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] b, input logic mack);
    logic oa, ob;
    sda_d = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #HALF; scl_d = 1'b1; oa = sda_oe; #(HALF/2); b[i] = sda_w;
      #(HALF/2); ob = sda_oe; if (oa !== ob) r11_bad = 1'b1; scl_d = 1'b0;
    end
    sda_d = ~mack; #HALF; scl_d = 1'b1; #HALF; scl_d = 1'b0; sda_d = 1'b1;
  endtask

  task automatic do_write(input int n);
    start_c();
    wbyte(8'hD2, ack); chk("R1 write address ack", ack, 1);
    wbyte(8'h5A, ack); chk("R2 command ack", ack, 1);
    wbyte(8'hA3, ack); chk("R2 count ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      wbyte(wd[k], ack);
      if (k < 6) begin chk("R3 data ack", ack, 1); mem[k] = wd[k]; end
      else chk("R8 extra byte ack", ack, 1);
    end
    stop_c();
    chk("R3 R4 R7 R8 cfg after write", cfg_o, expv());
  endtask

  task automatic do_read();
    r11_bad = 1'b0;
    start_c();
    wbyte(8'hD3, ack); chk("R1 read address ack", ack, 1);
    rbyte(rb, 1'b1); chk("R5 count byte", rb, 8'h07);
    for (int k = 0; k < 7; k++) begin
      rbyte(rb, k != 6);
      chk($sformatf("R5 read byte %0d", k), rb, expb(k));
    end
    stop_c();
    chk("R11 drive stable while SCL high", r11_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog R1..R11 act=hung exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int k = 0; k < 7; k++) mem[k] = DEFV[8*k +: 8];
    mem[0][2:0] = 3'b101;
    #48 rst_n = 1'b1;
    #96;
    fs_pin = 3'b010;
    chk("R6 R10 R7 reset image", cfg_o, 56'hFF_00_3F_C7_7F_87_15);
    do_read();

    start_c(); wbyte(8'hA4, ack); chk("R1 foreign address nack", ack, 0);
    wbyte(8'hFF, ack); chk("R1 stays released", ack, 0); stop_c();
    start_c(); wbyte(8'hD5, ack); chk("R1 foreign read address nack", ack, 0); stop_c();

    do_write(0);
    chk("R2 header only leaves image", cfg_o, 56'hFF_00_3F_C7_7F_87_15);

    for (int i = 0; i < 11; i++) begin
      for (int k = 0; k < 10; k++) wd[k] = 8'(i * 29 + k * 71 + 5) ^ {i[3:0], 4'h0};
      cpu_stop_pin = i[0]; pci_stop_pin = i[1]; mult_pin = i[2];
      do_write(8);
      do_read();
    end

    wd[0] = 8'hFF; wd[1] = 8'hFF;
    do_write(2);
    chk("R4 partial write bytes 2..6", cfg_o[55:16], expv() >> 16);
    wd[0] = 8'h00;
    do_write(1);
    chk("R4 restart at byte 0", cfg_o[15:0], {expb(1), expb(0)});
    chk("R10 fs field writable", cfg_o[2:0], 3'b000);

    cpu_stop_pin = ~cpu_stop_pin; mult_pin = ~mult_pin; #40;
    chk("R7 live mirror", cfg_o, expv());

    start_c(); wbyte(8'hD3, ack);
    rbyte(rb, 1'b1); rbyte(rb, 1'b1); rbyte(rb, 1'b0);
    chk("R9 third read byte is byte 1", rb, expb(1));
    start_c(); wbyte(8'hD3, ack); chk("R9 repeated start ack", ack, 1);
    rbyte(rb, 1'b1); chk("R9 count after repeated start", rb, 8'h07);
    rbyte(rb, 1'b0); chk("R9 byte 0 after count", rb, expb(0));
    stop_c();
    chk("R8 byte 6 constant", cfg_o[55:48], 8'hFF);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule